// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block sequences the memory bus of a small 8-bit processor whose address and data share one byte-wide output bus. Each instruction takes one to three memory cycles. Each cycle walks a fixed set of timing states. The first two states put a 14-bit address on the bus in two halves: first the low byte, then the six high bits together with a two-bit tag that names the kind of access. The sequencer then waits for the memory's READY, passes through a data state, and may pass through two further execution states. The current state is always visible as a 3-bit code on `status`.

An external instruction decoder looks at the instruction register and the cycle index that this block exports. From them it tells the sequencer how many cycles the instruction needs, the access kind of each later cycle, whether the two execution states are needed, and whether the opcode is a halt. READY and the interrupt line are asynchronous to the clock. Each passes through a two-flop synchronizer before it has any effect. A halt parks the sequencer until an interrupt wakes it.

Bytes read in later cycles come out on `cap_data` with a one-cycle `cap_valid` flag. This output has no back-pressure. The consumer must take the byte in the cycle where `cap_valid` is high, because it is never repeated or held for a ready signal.

Top module: `mbus_cycle_seq`

## Requirements
- R1: `status` uses these codes: T1=010, T1I=110, T2=100, WAIT=000, T3=001, STOPPED=011, T4=111, T5=101.
- R2: In T1 and T1I, `dout` carries bits 7:0 of the cycle's address and `sync` is 1.
- R3: In T2, `dout[5:0]` carries address bits 13:8 and `dout[7:6]` carries the access tag, with `sync` at 1. The tags are 00 instruction fetch, 01 data read, 10 I/O and 11 data write. Cycle 0 is always a fetch; a later cycle uses `dec_type`.
- R4: A fetch-tagged cycle uses the internal program counter, and the counter advances by one in T1. Any other cycle uses `data_addr` as sampled in T1. A fetch that starts in T1I does not advance the counter.
- R5: T2 always goes on to WAIT. WAIT goes to T3 only once synchronized READY is high. A high level on `ready_pin` in front of clock edge k can move WAIT to T3 at edge k+2 at the earliest.
- R6: The `din` byte present at the WAIT-to-T3 edge is captured, except in write cycles. In cycle 0 it goes to `ir`. In later cycles it goes to `cap_data`, and `cap_valid` is 1 for the whole of that T3.
- R7: In T3 of a write cycle, `dout` carries `wr_data` and `sync` is 1.
- R8: After T3 the sequencer enters T4 only when `dec_t4` is 1. After T4 it enters T5 only when `dec_t5` is 1.
- R9: When a cycle ends (T3 with no T4, T4 with no T5, or T5), the next state is T1. `cyc` increments when it is still below the instruction's cycle count, and otherwise returns to 0. A `dec_ncycles` of 0 counts as 1.
- R10: `dec_halt` seen in T3 of cycle 0 sends the sequencer to STOPPED. It stays there until synchronized INTR is high, then goes to T1I with `cyc` at 0.
- R11: `intr_pin` has no effect outside STOPPED. It reaches the state machine two edges after it is sampled.
- R12: Reset (active-low `rst_n`, asynchronous) gives T1, cycle 0, program counter 0, `ir` 0, so `dout` shows 0 with `sync` 1.
- R13: In WAIT, T4, T5, STOPPED and non-write T3, `sync` is 0 and `dout` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ready_pin | input | 1 | Memory ready, asynchronous |
| intr_pin | input | 1 | Interrupt request, asynchronous |
| din | input | 8 | Byte from memory or I/O |
| data_addr | input | 14 | Address used by non-fetch cycles |
| wr_data | input | 8 | Byte driven in a write cycle's T3 |
| dec_ncycles | input | 2 | Memory cycles of the current instruction |
| dec_type | input | 2 | Access tag of the current cycle (cycles after 0) |
| dec_t4 | input | 1 | Current cycle needs T4 |
| dec_t5 | input | 1 | Current cycle needs T5 |
| dec_halt | input | 1 | Instruction register holds a halt |
| status | output | 3 | Current timing-state code |
| dout | output | 8 | Multiplexed address/data output bus |
| sync | output | 1 | `dout` carries a valid address or data byte |
| cyc | output | 2 | Index of the current memory cycle |
| ir | output | 8 | Instruction register |
| cap_valid | output | 1 | `cap_data` holds a new operand byte |
| cap_data | output | 8 | Byte captured in a later cycle |

## Verification
The bench runs a program through a memory model that answers on the addresses seen on the bus. READY timing is varied from zero-wait to long stalls, so a sequencer that skipped the synchronizer, or leaked a stale READY into the next cycle, would drift out of step with the reference. Interrupt pulses arrive both while running and while halted. A design that honoured INTR outside STOPPED, or that advanced the program counter on the wake-up fetch, would put a wrong address on the bus. Immediate-operand fetches, I/O, data reads and writes are mixed with every T4/T5 combination. The bench also resets the block in the middle of a run and checks that it restarts cleanly at address 0. A wrong high-byte tag, a capture in a write cycle, or a cycle counter that failed to wrap would each show up on `dout`, `cap_valid` or `cyc` in the cycle where the fault occurs.

// File: rtl/mbseq_pkg.sv
package mbseq_pkg;

  // timing-state codes as they appear on the status port
  typedef enum logic [2:0] {
    ST_WAIT = 3'b000,
    ST_T3   = 3'b001,
    ST_T1   = 3'b010,
    ST_STOP = 3'b011,
    ST_T2   = 3'b100,
    ST_T5   = 3'b101,
    ST_T1I  = 3'b110,
    ST_T4   = 3'b111
  } tstate_e;

  // access tag sent in the upper bits of the second address phase
  typedef enum logic [1:0] {
    CT_FETCH = 2'b00,
    CT_READ  = 2'b01,
    CT_IO    = 2'b10,
    CT_WRITE = 2'b11
  } ctype_e;

endpackage

// File: rtl/mbseq_sync.sv
module mbseq_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  localparam int CHAIN_W = WIDTH * STAGES;

  logic [CHAIN_W-1:0] chain;

  if (STAGES == 1) begin : g_single
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= d;
    end
  end else begin : g_multi
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[CHAIN_W-WIDTH-1:0], d};
    end
  end

  assign q = chain[CHAIN_W-1 -: WIDTH];
endmodule

// File: rtl/mbseq_fsm.sv
module mbseq_fsm
  import mbseq_pkg::*;
#(
  parameter int MAX_CYCLES = 3,
  parameter int CYC_W      = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ready_s,
  input  logic             intr_s,
  input  logic [CYC_W-1:0] dec_ncycles,
  input  logic             dec_t4,
  input  logic             dec_t5,
  input  logic             dec_halt,
  output tstate_e          state,
  output logic [CYC_W-1:0] cyc
);
  localparam int CNT_W = CYC_W + 1;

  tstate_e          state_d;
  logic [CYC_W-1:0] cyc_d;
  logic [CNT_W-1:0] cyc_inc;
  logic [CNT_W-1:0] limit;
  logic             last_cyc;
  logic             close_cyc;

  // cycle budget of the instruction in flight
  always_comb begin
    cyc_inc = {1'b0, cyc} + CNT_W'(1);
    limit   = (dec_ncycles == '0) ? CNT_W'(1) : {1'b0, dec_ncycles};
    if (limit > CNT_W'(MAX_CYCLES)) limit = CNT_W'(MAX_CYCLES);
    last_cyc = (cyc_inc >= limit);
  end

  always_comb begin
    state_d   = state;
    cyc_d     = cyc;
    close_cyc = 1'b0;
    unique case (state)
      ST_T1, ST_T1I: state_d = ST_T2;
      ST_T2:         state_d = ST_WAIT;
      ST_WAIT:       if (ready_s) state_d = ST_T3;
      ST_T3: begin
        if (cyc == '0 && dec_halt) state_d = ST_STOP;
        else if (dec_t4)           state_d = ST_T4;
        else                       close_cyc = 1'b1;
      end
      ST_T4: begin
        if (dec_t5) state_d = ST_T5;
        else        close_cyc = 1'b1;
      end
      ST_T5:   close_cyc = 1'b1;
      ST_STOP: begin
        if (intr_s) begin
          state_d = ST_T1I;
          cyc_d   = '0;
        end
      end
    endcase
    if (close_cyc) begin
      state_d = ST_T1;
      cyc_d   = last_cyc ? '0 : cyc_inc[CYC_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_T1;
      cyc   <= '0;
    end else begin
      state <= state_d;
      cyc   <= cyc_d;
    end
  end
endmodule

// File: rtl/mbseq_bus.sv
module mbseq_bus
  import mbseq_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int BUS_W  = 8,
  parameter int CYC_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tstate_e           state,
  input  logic [CYC_W-1:0]  cyc,
  input  logic              ready_s,
  input  logic [1:0]        dec_type,
  input  logic [ADDR_W-1:0] data_addr,
  input  logic [BUS_W-1:0]  wr_data,
  input  logic [BUS_W-1:0]  din,
  output logic [BUS_W-1:0]  dout,
  output logic              sync,
  output logic [BUS_W-1:0]  ir,
  output logic              cap_valid,
  output logic [BUS_W-1:0]  cap_data
);
  localparam int HI_W = ADDR_W - BUS_W;

  logic [ADDR_W-1:0] pc;
  logic [ADDR_W-1:0] addr_q;
  ctype_e            type_q;
  ctype_e            cur_type;
  logic [ADDR_W-1:0] sel_addr;
  logic              addr_phase;
  logic              take_byte;

  assign cur_type   = (cyc == '0) ? CT_FETCH : ctype_e'(dec_type);
  assign sel_addr   = (cur_type == CT_FETCH) ? pc : data_addr;
  assign addr_phase = (state == ST_T1) || (state == ST_T1I);
  assign take_byte  = (state == ST_WAIT) && ready_s && (type_q != CT_WRITE);

  // address hold and program counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc     <= '0;
      addr_q <= '0;
      type_q <= CT_FETCH;
    end else if (addr_phase) begin
      addr_q <= sel_addr;
      type_q <= cur_type;
      if (state == ST_T1 && cur_type == CT_FETCH) pc <= pc + ADDR_W'(1);
    end
  end

  // byte capture on the edge that enters T3
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ir       <= '0;
      cap_data <= '0;
    end else if (take_byte) begin
      if (cyc == '0) ir       <= din;
      else           cap_data <= din;
    end
  end

  assign cap_valid = (state == ST_T3) && (cyc != '0) && (type_q != CT_WRITE);

  // output bus multiplexer
  always_comb begin
    dout = '0;
    sync = 1'b0;
    case (state)
      ST_T1, ST_T1I: begin
        dout = sel_addr[BUS_W-1:0];
        sync = 1'b1;
      end
      ST_T2: begin
        dout = BUS_W'({type_q, addr_q[BUS_W +: HI_W]});
        sync = 1'b1;
      end
      ST_T3: begin
        if (type_q == CT_WRITE) begin
          dout = wr_data;
          sync = 1'b1;
        end
      end
      default: begin
        dout = '0;
        sync = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/mbus_cycle_seq.sv
module mbus_cycle_seq
  import mbseq_pkg::*;
#(
  parameter int  ADDR_W      = 14,
  parameter int  BUS_W       = 8,
  parameter int  MAX_CYCLES  = 3,
  parameter int  SYNC_STAGES = 2,
  localparam int CYC_W       = $clog2(MAX_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ready_pin,
  input  logic              intr_pin,
  input  logic [BUS_W-1:0]  din,
  input  logic [ADDR_W-1:0] data_addr,
  input  logic [BUS_W-1:0]  wr_data,
  input  logic [CYC_W-1:0]  dec_ncycles,
  input  logic [1:0]        dec_type,
  input  logic              dec_t4,
  input  logic              dec_t5,
  input  logic              dec_halt,
  output logic [2:0]        status,
  output logic [BUS_W-1:0]  dout,
  output logic              sync,
  output logic [CYC_W-1:0]  cyc,
  output logic [BUS_W-1:0]  ir,
  output logic              cap_valid,
  output logic [BUS_W-1:0]  cap_data
);
  logic    ready_s;
  logic    intr_s;
  tstate_e state;

  mbseq_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({intr_pin, ready_pin}),
    .q     ({intr_s, ready_s})
  );

  mbseq_fsm #(.MAX_CYCLES(MAX_CYCLES), .CYC_W(CYC_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .ready_s     (ready_s),
    .intr_s      (intr_s),
    .dec_ncycles (dec_ncycles),
    .dec_t4      (dec_t4),
    .dec_t5      (dec_t5),
    .dec_halt    (dec_halt),
    .state       (state),
    .cyc         (cyc)
  );

  mbseq_bus #(.ADDR_W(ADDR_W), .BUS_W(BUS_W), .CYC_W(CYC_W)) u_bus (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state),
    .cyc       (cyc),
    .ready_s   (ready_s),
    .dec_type  (dec_type),
    .data_addr (data_addr),
    .wr_data   (wr_data),
    .din       (din),
    .dout      (dout),
    .sync      (sync),
    .ir        (ir),
    .cap_valid (cap_valid),
    .cap_data  (cap_data)
  );

  assign status = state;
endmodule

// File: rtl/mbus_cycle_seq_chk.sv
module mbus_cycle_seq_chk #(
  parameter int BUS_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       status,
  input logic [BUS_W-1:0] dout,
  input logic             sync,
  input logic             ready_s,
  input logic             intr_s
);
  localparam logic [2:0] C_WAIT = 3'b000;
  localparam logic [2:0] C_T3   = 3'b001;
  localparam logic [2:0] C_T1   = 3'b010;
  localparam logic [2:0] C_STOP = 3'b011;
  localparam logic [2:0] C_T2   = 3'b100;
  localparam logic [2:0] C_T5   = 3'b101;
  localparam logic [2:0] C_T1I  = 3'b110;
  localparam logic [2:0] C_T4   = 3'b111;

  a_r3_addr_to_t2: assert property (@(posedge clk) disable iff (!rst_n)
    (status == C_T1 || status == C_T1I) |=> (status == C_T2));

  a_r5_t2_to_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (status == C_T2) |=> (status == C_WAIT));

  a_r5_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (status == C_WAIT && !ready_s) |=> (status == C_WAIT));

  a_r5_wait_exits: assert property (@(posedge clk) disable iff (!rst_n)
    (status == C_WAIT && ready_s) |=> (status == C_T3));

  a_r8_t5_after_t4: assert property (@(posedge clk) disable iff (!rst_n)
    (status == C_T5) |-> ($past(status) == C_T4));

  a_r10_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (status == C_STOP && !intr_s) |=> (status == C_STOP));

  a_r10_wake_t1i: assert property (@(posedge clk) disable iff (!rst_n)
    (status == C_STOP && intr_s) |=> (status == C_T1I));

  a_r11_t1i_only_from_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (status == C_T1I) |-> ($past(status) == C_STOP));

  a_r2_sync_in_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (status == C_T1 || status == C_T1I || status == C_T2) |-> sync);

  a_r13_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (status == C_WAIT || status == C_T4 || status == C_T5 || status == C_STOP)
      |-> (!sync && dout == '0));

  a_r7_sync_only_t3_data: assert property (@(posedge clk) disable iff (!rst_n)
    (status == C_T3 && sync) |=> (status != C_T3));
endmodule

bind mbus_cycle_seq mbus_cycle_seq_chk #(.BUS_W(BUS_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .status  (status),
  .dout    (dout),
  .sync    (sync),
  .ready_s (ready_s),
  .intr_s  (intr_s)
);

// File: tb/mbus_cycle_seq_test.sv
module mbus_cycle_seq_test;
  localparam logic [2:0] S_WAIT = 3'b000;
  localparam logic [2:0] S_T3   = 3'b001;
  localparam logic [2:0] S_T1   = 3'b010;
  localparam logic [2:0] S_STOP = 3'b011;
  localparam logic [2:0] S_T2   = 3'b100;
  localparam logic [2:0] S_T5   = 3'b101;
  localparam logic [2:0] S_T1I  = 3'b110;
  localparam logic [2:0] S_T4   = 3'b111;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0, ready_pin = 1'b0, intr_pin = 1'b0;
  logic [7:0]  din = 8'h00, wr_data = 8'h00;
  logic [13:0] data_addr = 14'h0000;
  logic [1:0]  dn, dt;
  logic        d4, d5, dh;
  logic [2:0]  status;
  logic [7:0]  dout, ir, cap_data;
  logic        sync, cap_valid;
  logic [1:0]  cyc;

  mbus_cycle_seq uut (
    .clk(clk), .rst_n(rst_n), .ready_pin(ready_pin), .intr_pin(intr_pin),
    .din(din), .data_addr(data_addr), .wr_data(wr_data),
    .dec_ncycles(dn), .dec_type(dt), .dec_t4(d4), .dec_t5(d5), .dec_halt(dh),
    .status(status), .dout(dout), .sync(sync), .cyc(cyc), .ir(ir),
    .cap_valid(cap_valid), .cap_data(cap_data)
  );

  // environment decoder: {ncycles, type, t4, t5, halt}
  function automatic logic [6:0] decode(input logic [7:0] op, input logic [1:0] c);
    logic [1:0] n, ty;
    logic t4, t5, h;
    h = (op == 8'hFF);
    case (op[5:4])
      2'd0:    n = 2'd1;
      2'd1:    n = 2'd2;
      default: n = 2'd3;
    endcase
    ty = (op[5:4] == 2'd2 && c == 2'd1) ? 2'b00 : op[3:2];
    t4 = (c == 2'd0) ? op[0] : op[6];
    t5 = (c == 2'd0) ? op[1] : op[7];
    return {n, ty, t4, t5, h};
  endfunction

  function automatic logic [7:0] prog(input logic [5:0] a);
    case (a)
      6'd0:  return 8'h03;  6'd1:  return 8'h01;  6'd2:  return 8'h00;
      6'd3:  return 8'h14;  6'd4:  return 8'h58;  6'd5:  return 8'hDC;
      6'd6:  return 8'h20;  6'd9:  return 8'h2D;  6'd11: return 8'h3A;
      6'd12: return 8'hFF;  6'd13: return 8'h02;  6'd14: return 8'h34;
      6'd15: return 8'hFF;  6'd16: return 8'h10;  6'd18: return 8'hE7;
      default: return a[0] ? 8'h01 : 8'h12;
    endcase
  endfunction

  function automatic logic [7:0] mem(input logic [13:0] a);
    if (a < 14'd64) return prog(a[5:0]);
    return a[7:0] ^ 8'h5A;
  endfunction

  always_comb {dn, dt, d4, d5, dh} = decode(ir, cyc);

  // behavioural reference model
  logic [2:0]  m_state;
  logic [1:0]  m_cyc, m_type;
  logic [13:0] m_pc, m_addr;
  logic [7:0]  m_ir, m_data;
  logic        m_r1, m_r2, m_i1, m_i2;
  logic [6:0]  md;
  logic [1:0]  mct;
  bit          mclose;
  int          mlim;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = S_T1; m_cyc = 0; m_type = 0; m_pc = 0; m_addr = 0;
      m_ir = 0; m_data = 0; m_r1 = 0; m_r2 = 0; m_i1 = 0; m_i2 = 0;
    end else begin
      md = decode(m_ir, m_cyc);
      mct = (m_cyc == 0) ? 2'b00 : md[4:3];
      mclose = 0;
      case (m_state)
        S_T1: begin
          m_addr = (mct == 0) ? m_pc : data_addr;
          m_type = mct;
          if (mct == 0) m_pc = m_pc + 14'd1;
          m_state = S_T2;
        end
        S_T1I: begin
          m_addr = m_pc; m_type = 2'b00; m_state = S_T2;
        end
        S_T2: m_state = S_WAIT;
        S_WAIT: if (m_r2) begin
          if (m_type != 2'b11) begin
            if (m_cyc == 0) m_ir = din; else m_data = din;
          end
          m_state = S_T3;
        end
        S_T3: begin
          if (m_cyc == 0 && md[0]) m_state = S_STOP;
          else if (md[2]) m_state = S_T4;
          else mclose = 1;
        end
        S_T4: if (md[1]) m_state = S_T5; else mclose = 1;
        S_T5: mclose = 1;
        default: if (m_i2) begin m_state = S_T1I; m_cyc = 0; end
      endcase
      if (mclose) begin
        mlim = (md[6:5] == 0) ? 1 : int'(md[6:5]);
        m_cyc = (int'(m_cyc) + 1 < mlim) ? m_cyc + 2'd1 : 2'd0;
        m_state = S_T1;
      end
      m_r2 = m_r1; m_r1 = ready_pin;
      m_i2 = m_i1; m_i1 = intr_pin;
    end
  end

  int  checks = 0, fails = 0;
  int  obs_t1i = 0, mdl_t1i = 0;
  bit  done = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic string stag(input logic [2:0] s, input bit ilive);
    if (ilive && s != S_STOP) return "R1 R11";
    case (s)
      S_WAIT:       return "R1 R5";
      S_T3:         return "R1 R6";
      S_T1:         return "R1 R9";
      S_T1I:        return "R1 R10";
      S_T2:         return "R1 R3";
      S_T4, S_T5:   return "R1 R8";
      default:      return "R1 R10";
    endcase
  endfunction

  task automatic compare();
    logic [6:0]  ed;
    logic [1:0]  ect;
    logic [13:0] esel;
    logic [7:0]  edout;
    logic        esync, ecap;
    string       btag;
    ed = decode(m_ir, m_cyc);
    ect = (m_cyc == 0) ? 2'b00 : ed[4:3];
    esel = (ect == 0) ? m_pc : data_addr;
    edout = 8'h00; esync = 0; btag = "R13";
    case (m_state)
      S_T1, S_T1I: begin edout = esel[7:0]; esync = 1; btag = "R2 R4"; end
      S_T2: begin edout = {m_type, m_addr[13:8]}; esync = 1; btag = "R3 R4"; end
      S_T3: if (m_type == 2'b11) begin edout = wr_data; esync = 1; btag = "R7"; end
      default: ;
    endcase
    ecap = (m_state == S_T3) && (m_cyc != 0) && (m_type != 2'b11);
    chk(status == m_state, stag(m_state, m_i2), "status", status, m_state);
    chk(dout == edout, btag, "dout", dout, edout);
    chk(sync == esync, btag, "sync", sync, esync);
    chk(cyc == m_cyc, "R9", "cyc", cyc, m_cyc);
    chk(ir == m_ir, "R6", "ir", ir, m_ir);
    chk(cap_valid == ecap, "R6", "cap_valid", cap_valid, ecap);
    if (ecap) chk(cap_data == m_data, "R6", "cap_data", cap_data, m_data);
    if (status == S_T1I) obs_t1i++;
    if (m_state == S_T1I) mdl_t1i++;
  endtask

  task automatic reset_check();
    chk(status == S_T1, "R12", "reset status", status, S_T1);
    chk(dout == 8'h00 && sync == 1'b1, "R12", "reset bus", {sync, dout}, 9'h100);
    chk(cyc == 2'd0 && ir == 8'h00, "R12", "reset cyc/ir", {cyc, ir}, 0);
  endtask

  logic [7:0]  ob_lo = 0;
  logic [5:0]  ob_hi = 0;
  logic [15:0] lf = 16'hACE1;

  task automatic run(input int ncyc, input int phase);
    for (int t = 0; t < ncyc; t++) begin
      @(negedge clk);
      compare();
      if (status == S_T1 || status == S_T1I) ob_lo = dout;
      if (status == S_T2) ob_hi = dout[5:0];
      din = mem({ob_hi, ob_lo});
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      case (phase)
        0:       ready_pin = 1'b1;
        1:       ready_pin = lf[0] | lf[3];
        default: ready_pin = lf[1] & lf[2] & lf[5];
      endcase
      intr_pin = ((t % 97) == 50);
      data_addr = 14'h2000 | 14'((t * 37) & 12'hFFF);
      wr_data = 8'(t * 11 + 3);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    #1 reset_check();
    rst_n = 1'b1;
    run(400, 0);
    run(1500, 1);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1 reset_check();
    ob_lo = 0; ob_hi = 0; din = mem(14'd0);
    rst_n = 1'b1;
    run(1200, 2);
    run(300, 0);
    chk(obs_t1i == mdl_t1i, "R11", "wake count", obs_t1i, mdl_t1i);
    chk(obs_t1i > 0, "R10", "wake seen", obs_t1i, 1);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R9 watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule